// File: doc/BRIEF.md
# Local Countdown Timer with Prescaler

This block is a per-core interrupt timer. Software loads a starting value into a count register; from then on the value steps down by one on every prescaled tick until it reaches zero. A small setup register picks how many input ticks make one prescaled tick, and a timer entry register holds the interrupt vector, a mask bit and a mode bit that chooses between a single countdown and an endless reloading countdown. Each time the count arrives at zero and the entry is not masked, the block emits a one-cycle interrupt pulse that carries the 8-bit vector.

The block is clocked by the core clock and advances only on cycles where the tick enable input is high, so the time base comes from outside. Registers are reached through a simple word port: a write strobe with address and data, and a read bus that shows the addressed register combinationally. Addresses are word indexes: timer entry 0x32, starting count 0x38, live count 0x39, prescaler setup 0x3E.

Top module: `lct_timer`

## Requirements
- R1: After reset the starting count, live count and prescaler setup read 0, the timer entry reads 0x0001_0000 (masked, single mode, vector 0) and no interrupt is issued.
- R2: A write to the prescaler setup at 0x3E keeps only data bits 0, 1 and 3; every other bit reads back as 0.
- R3: The prescaler setup forms a 3-bit code from bit 3 (code msb) and bits 1:0; one prescaled tick takes 2^((code+1) mod 8) enabled input ticks, so code 7 steps the count on every enabled tick.
- R4: In single mode (entry bit 17 = 0) the live count drops by one per prescaled tick, stays at 0 once reached, and the run gives exactly one interrupt.
- R5: In reloading mode (entry bit 17 = 1) the prescaled tick after the count reads 0 restores the starting count, so the period is starting count + 1 prescaled ticks with one interrupt per period.
- R6: Writing the starting count at 0x38 sets the live count to the written value on that edge and clears the prescaler, restarting the countdown.
- R7: A starting count of 0 leaves the timer stopped: the live count stays 0 and no interrupt is issued.
- R8: With entry bit 16 set the interrupt is suppressed while the count still runs.
- R9: The interrupt output is high for one cycle, in the cycle right after the edge on which the count reaches 0, and carries entry bits 7:0 as vector; otherwise the vector output is 0.
- R10: The live count register at 0x39 is read-only; writes to it change nothing.
- R11: On cycles with the tick enable low the live count and the prescaler do not move.
- R12: Addresses other than the four listed read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time base enable; one input tick per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word index |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read of the addressed register |
| irq_valid | output | 1 | One-cycle expiry interrupt pulse |
| irq_vector | output | 8 | Vector delivered with the pulse, 0 when idle |

## Verification
A register write lands on the edge that samples it, so the read bus shows the new value in the following cycle, and the expiry pulse rises in the cycle just after the edge on which the count reaches zero, together with a live count of 0. With a prescale ratio of r and a starting value of n, the first pulse is therefore due n*r edges after the loading edge. The bench keeps a behavioural model updated on the same rising edge as the design and compares pulse, vector and read bus at the falling edge, while the directed checks count edges from the load to the pulse and count pulses in fixed windows against these figures.

// File: rtl/lct_pkg.sv
package lct_pkg;

   // Word indexes of the registers
   localparam logic [7:0] OFF_ENTRY = 8'h32;
   localparam logic [7:0] OFF_START = 8'h38;
   localparam logic [7:0] OFF_LIVE  = 8'h39;
   localparam logic [7:0] OFF_PRESC = 8'h3E;

   // Bits kept by the prescaler setup register
   localparam logic [3:0] PRESC_KEEP = 4'b1011;

   // Entry bit positions
   localparam int ENTRY_MASK_BIT = 16;
   localparam int ENTRY_MODE_BIT = 17;

   // Largest prescale shift the 3-bit code can produce
   localparam int MAX_SHIFT = 7;

   typedef struct packed {
      logic       periodic;
      logic       masked;
      logic [7:0] vector;
   } entry_t;

   // Code {b3,b1,b0} -> shift (code+1) mod 8
   function automatic logic [2:0] presc_shift(input logic [3:0] setup);
      logic [2:0] code;
      code = {setup[3], setup[1:0]};
      return code + 3'd1;
   endfunction

endpackage

// File: rtl/lct_regs.sv
module lct_regs
   import lct_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int CNT_W       = 32,
   parameter bit PERIODIC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [CNT_W-1:0]  live_cnt,
   output logic [DATA_W-1:0] rd_data,
   output logic              start_load,
   output logic [CNT_W-1:0]  start_q,
   output logic [3:0]        presc_q,
   output entry_t            entry_q
);

   localparam logic [ADDR_W-1:0] A_ENTRY = ADDR_W'(OFF_ENTRY);
   localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFF_START);
   localparam logic [ADDR_W-1:0] A_LIVE  = ADDR_W'(OFF_LIVE);
   localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(OFF_PRESC);

   logic wr_entry, wr_presc;

   assign start_load = wr_en && (addr == A_START);
   assign wr_entry   = wr_en && (addr == A_ENTRY);
   assign wr_presc   = wr_en && (addr == A_PRESC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         presc_q <= '0;
      end else begin
         if (start_load) start_q <= wr_data[CNT_W-1:0];
         if (wr_presc)   presc_q <= wr_data[3:0] & PRESC_KEEP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         entry_q.masked <= 1'b1;
         entry_q.vector <= '0;
      end else if (wr_entry) begin
         entry_q.masked <= wr_data[ENTRY_MASK_BIT];
         entry_q.vector <= wr_data[7:0];
      end
   end

   generate
      if (PERIODIC_EN) begin : g_mode_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        entry_q.periodic <= 1'b0;
            else if (wr_entry) entry_q.periodic <= wr_data[ENTRY_MODE_BIT];
         end
      end else begin : g_mode_tie
         assign entry_q.periodic = 1'b0;
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      case (addr)
         A_ENTRY: begin
            rd_data[7:0]           = entry_q.vector;
            rd_data[ENTRY_MASK_BIT] = entry_q.masked;
            rd_data[ENTRY_MODE_BIT] = entry_q.periodic;
         end
         A_START: rd_data[CNT_W-1:0] = start_q;
         A_LIVE:  rd_data[CNT_W-1:0] = live_cnt;
         A_PRESC: rd_data[3:0]       = presc_q;
         default: rd_data = '0;
      endcase
   end

endmodule

// File: rtl/lct_prescaler.sv
module lct_prescaler
   import lct_pkg::*;
#(
   parameter int PRE_W = MAX_SHIFT
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       clear,
   input  logic [2:0] shift,
   output logic       strobe
);

   logic [PRE_W-1:0] pcnt_q;
   logic [PRE_W-1:0] limit;

   // ratio - 1 for ratio = 2^shift
   assign limit  = PRE_W'(({{(PRE_W-1){1'b0}}, 1'b1} << shift) - 1'b1);
   assign strobe = tick_en && (pcnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pcnt_q <= '0;
      else if (clear)   pcnt_q <= '0;
      else if (tick_en) pcnt_q <= strobe ? '0 : pcnt_q + 1'b1;
   end

endmodule

// File: rtl/lct_counter.sv
module lct_counter #(
   parameter int CNT_W       = 32,
   parameter bit PERIODIC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             strobe,
   input  logic             periodic,
   output logic [CNT_W-1:0] cnt_q,
   output logic             fire
);

   logic run_q;
   logic per_eff;

   generate
      if (PERIODIC_EN) begin : g_per
         assign per_eff = periodic;
      end else begin : g_oneshot
         assign per_eff = 1'b0;
      end
   endgenerate

   assign fire = strobe && run_q && !load && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load) begin
         cnt_q <= load_val;
         run_q <= |load_val;
      end else if (strobe && run_q) begin
         if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
         else if (per_eff) cnt_q <= reload_val;
         else              run_q <= 1'b0;
      end
   end

endmodule

// File: rtl/lct_timer.sv
module lct_timer
   import lct_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int CNT_W       = 32,
   parameter bit PERIODIC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_valid,
   output logic [7:0]        irq_vector
);

   localparam int PRE_W = MAX_SHIFT;

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("lct_timer: ADDR_W must be at least 8");
      end
      if (DATA_W < ENTRY_MODE_BIT + 1) begin : g_bad_data
         $error("lct_timer: DATA_W too small for the entry fields");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("lct_timer: CNT_W must lie in 2..DATA_W");
      end
   endgenerate

   logic             start_load;
   logic [CNT_W-1:0] start_q;
   logic [CNT_W-1:0] cnt_q;
   logic [3:0]       presc_q;
   entry_t           entry_q;
   logic             strobe;
   logic             fire;

   lct_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PERIODIC_EN(PERIODIC_EN)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .live_cnt(cnt_q), .rd_data(rd_data), .start_load(start_load),
      .start_q(start_q), .presc_q(presc_q), .entry_q(entry_q)
   );

   lct_prescaler #(.PRE_W(PRE_W)) presc_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clear(start_load),
      .shift(presc_shift(presc_q)), .strobe(strobe)
   );

   lct_counter #(.CNT_W(CNT_W), .PERIODIC_EN(PERIODIC_EN)) cnt_i (
      .clk(clk), .rst_n(rst_n), .load(start_load),
      .load_val(wr_data[CNT_W-1:0]), .reload_val(start_q),
      .strobe(strobe), .periodic(entry_q.periodic),
      .cnt_q(cnt_q), .fire(fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid  <= 1'b0;
         irq_vector <= '0;
      end else begin
         irq_valid  <= fire && !entry_q.masked;
         irq_vector <= (fire && !entry_q.masked) ? entry_q.vector : 8'h00;
      end
   end

endmodule

// File: rtl/lct_timer_chk.sv
module lct_timer_chk
   import lct_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              irq_valid,
   input logic [7:0]        irq_vector,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [CNT_W-1:0]  start_q
);

   logic load_w;
   assign load_w = wr_en && (addr == ADDR_W'(OFF_START));

   // R9
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |=> !irq_valid);

   // R9
   vec_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_valid |-> (irq_vector == 8'h00));

   // R4
   irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (cnt_q == '0));

   // R11
   hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !load_w) |=> $stable(cnt_q));

   // R6
   load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_w |=> (cnt_q == $past(wr_data[CNT_W-1:0])));

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= start_q);

   // R2
   presc_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(OFF_PRESC)) |-> (rd_data[DATA_W-1:4] == '0 && !rd_data[2]));

   // R7
   zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q == '0 && !load_w) |=> (cnt_q == '0));

endmodule

bind lct_timer lct_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
   .wr_data(wr_data), .rd_data(rd_data), .irq_valid(irq_valid),
   .irq_vector(irq_vector), .cnt_q(cnt_q), .start_q(start_q)
);

// File: tb/lct_timer_tb.sv
module lct_timer_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h39;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        irq_valid;
   logic [7:0]  irq_vector;

   int errors = 0;
   int checks = 0;
   int tick_mode = 0;
   int tick_cnt = 0;
   string phase_tag = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   lct_timer dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .irq_valid(irq_valid),
      .irq_vector(irq_vector)
   );

   // reference model state
   logic [31:0] m_start, m_cur;
   logic [3:0]  m_presc_setup;
   logic        m_run, m_mask, m_per, m_irq;
   logic [7:0]  m_vec, m_irqv;
   int          m_pcnt;

   function automatic int ratio_of(input logic [3:0] s);
      int code;
      code = {s[3], s[1:0]};
      return 1 << ((code + 1) % 8);
   endfunction

   function automatic logic [31:0] exp_rd(input logic [7:0] a);
      case (a)
         8'h32: return {14'b0, m_per, m_mask, 8'b0, m_vec};
         8'h38: return m_start;
         8'h39: return m_cur;
         8'h3E: return {28'b0, m_presc_setup};
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_start = 0; m_cur = 0; m_presc_setup = 0; m_run = 0;
         m_mask = 1; m_per = 0; m_vec = 0; m_irq = 0; m_irqv = 0; m_pcnt = 0;
      end else begin
         logic strobe, ld, fire;
         strobe = tick_en && (m_pcnt >= ratio_of(m_presc_setup) - 1);
         ld = wr_en && addr == 8'h38;
         fire = 0;
         if (ld) begin
            m_cur = wr_data; m_run = (wr_data != 0);
         end else if (strobe && m_run) begin
            if (m_cur != 0) begin
               m_cur = m_cur - 1; fire = (m_cur == 0);
            end else if (m_per) m_cur = m_start;
            else m_run = 0;
         end
         if (ld) m_pcnt = 0;
         else if (tick_en) m_pcnt = strobe ? 0 : m_pcnt + 1;
         m_irq  = fire && !m_mask;
         m_irqv = m_irq ? m_vec : 8'h00;
         if (wr_en) begin
            case (addr)
               8'h32: begin m_vec = wr_data[7:0]; m_mask = wr_data[16]; m_per = wr_data[17]; end
               8'h38: m_start = wr_data;
               8'h3E: m_presc_setup = wr_data[3:0] & 4'hB;
               default: ;
            endcase
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp, input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=0x%08h expected=0x%08h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check(irq_valid == m_irq, "R9", 32'(irq_valid), 32'(m_irq), "pulse vs model");
         check(irq_vector == m_irqv, "R9", 32'(irq_vector), 32'(m_irqv), "vector vs model");
         check(rd_data == exp_rd(addr), phase_tag, rd_data, exp_rd(addr), "read vs model");
      end
   end

   // time base
   always @(posedge clk) begin
      #1;
      tick_cnt++;
      tick_en = (tick_mode == 1) ? 1'b1 : (tick_mode == 2) ? (tick_cnt % 3 == 0) : 1'b0;
   end

   task automatic do_write(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0; addr = 8'h39;
   endtask

   task automatic do_read(input logic [7:0] a, output logic [31:0] d);
      @(posedge clk); #1;
      addr = a;
      #2 d = rd_data;
      @(negedge clk);
      @(posedge clk); #1;
      addr = 8'h39;
   endtask

   task automatic count_pulses(input int n, output int p);
      p = 0;
      repeat (n) begin
         @(posedge clk); #1;
         if (irq_valid) p++;
      end
   endtask

   task automatic edges_to_pulse(output int n);
      n = 0;
      do begin
         @(posedge clk); #1;
         n++;
      end while (!irq_valid && n < 1000);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int n;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset values
      phase_tag = "R1";
      do_read(8'h38, v); check(v == 0, "R1", v, 0, "start count after reset");
      do_read(8'h39, v); check(v == 0, "R1", v, 0, "live count after reset");
      do_read(8'h3E, v); check(v == 0, "R1", v, 0, "prescaler after reset");
      do_read(8'h32, v); check(v == 32'h0001_0000, "R1", v, 32'h0001_0000, "entry after reset");
      // R12 unmapped read
      phase_tag = "R12";
      do_read(8'h20, v); check(v == 0, "R12", v, 0, "unmapped read");

      // R2 prescaler masking
      phase_tag = "R2";
      do_write(8'h3E, 32'hFFFF_FFFF);
      do_read(8'h3E, v); check(v == 32'hB, "R2", v, 32'hB, "prescaler keeps bits 0,1,3");

      // R4 single mode, code 7 -> every tick
      phase_tag = "R4";
      tick_mode = 1;
      do_write(8'h32, 32'h0000_005A);
      do_write(8'h38, 32'd5);
      count_pulses(20, n); check(n == 1, "R4", n, 1, "single mode pulse count");
      do_read(8'h39, v); check(v == 0, "R4", v, 0, "single mode holds at 0");

      // R3 ratio 4 (setup 0x1), start 3 -> 12 edges
      phase_tag = "R3";
      do_write(8'h3E, 32'h1);
      do_write(8'h38, 32'd3);
      edges_to_pulse(n); check(n == 12, "R3", n, 12, "edges to pulse at ratio 4");
      // R3 ratio 2 (setup 0), start 4 -> 8 edges
      do_write(8'h3E, 32'h0);
      do_write(8'h38, 32'd4);
      edges_to_pulse(n); check(n == 8, "R3", n, 8, "edges to pulse at ratio 2");
      check(irq_vector == 8'h5A, "R9", irq_vector, 8'h5A, "vector with pulse");

      // R5 reloading mode, ratio 1, start 2 -> period 3
      phase_tag = "R5";
      do_write(8'h3E, 32'hB);
      do_write(8'h32, 32'h0002_00A7);
      do_write(8'h38, 32'd2);
      count_pulses(30, n); check(n == 10, "R5", n, 10, "reloading pulses in 30 edges");

      // R8 mask suppresses pulses
      phase_tag = "R8";
      do_write(8'h32, 32'h0003_00A7);
      do_write(8'h38, 32'd2);
      count_pulses(30, n); check(n == 0, "R8", n, 0, "masked pulses");

      // R6 restart while running
      phase_tag = "R6";
      do_write(8'h32, 32'h0002_00A7);
      do_write(8'h38, 32'd100);
      repeat (10) @(posedge clk);
      do_write(8'h38, 32'd3);
      check(rd_data == 3, "R6", rd_data, 3, "live count right after load");
      edges_to_pulse(n); check(n == 3, "R6", n, 3, "edges to pulse after restart");

      // R7 zero start stops the timer
      phase_tag = "R7";
      do_write(8'h38, 32'd0);
      count_pulses(20, n); check(n == 0, "R7", n, 0, "no pulse with zero start");
      do_read(8'h39, v); check(v == 0, "R7", v, 0, "live count with zero start");

      // R11 no ticks, R10 live count read-only
      phase_tag = "R11";
      tick_mode = 0;
      @(posedge clk);
      do_write(8'h38, 32'd9);
      phase_tag = "R10";
      do_write(8'h39, 32'd3);
      repeat (10) @(posedge clk);
      do_read(8'h39, v); check(v == 9, "R10", v, 9, "live count ignores writes, R11 frozen");
      count_pulses(10, n); check(n == 0, "R11", n, 0, "no pulse without ticks");

      // sparse ticks, ratio 2, single mode through the model
      phase_tag = "R4";
      do_write(8'h3E, 32'h0);
      do_write(8'h32, 32'h0000_0033);
      tick_mode = 2;
      do_write(8'h38, 32'd4);
      count_pulses(60, n); check(n == 1, "R4", n, 1, "sparse ticks single pulse");

      // R12 unmapped writes ignored
      phase_tag = "R12";
      do_write(8'h20, 32'hFFFF_FFFF);
      do_read(8'h20, v); check(v == 0, "R12", v, 0, "unmapped after write");
      do_read(8'h3E, v); check(v == 0, "R12", v, 0, "prescaler untouched by unmapped write");

      repeat (4) @(posedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule